// File: doc/BRIEF.md
# PWM Timer with Buffered Reload

This block is a shared-counter PWM timer with a small set of compare channels. One counter, stepped by a power-of-two prescaler, runs either as an up counter that wraps, which gives edge-aligned pulses, or as an up-down counter, which gives center-aligned pulses. Each channel drives its pin active while the count is below its compare value. Each even/odd channel pair can be switched to combined mode. In that mode both pins of the pair carry a single pulse: its leading edge is placed by the even value and its trailing edge by the odd value.

Software writes the period (modulus), the counter start value and the compare values into shadow buffers through a simple write port. The active copies change only at a reload point or on a software sync strike, so a new duty cycle never cuts a period in half. The reload points are the top of the count, the bottom of an up-down count, and a match on a selected channel. Compare buffers of a pair move only when that pair's sync enable is set. A sticky overflow flag marks each period. Per-channel polarity and initial-output settings shape the pins.

Top module: `pwm_timer`

## Requirements
- R1: After reset the count is 0, all PWM outputs are 0, the overflow flag is 0 and the counter is stopped.
- R2: When running, the count advances once every 2^PS clocks, where PS is control register (address 0) bits [2:0].
- R3: In edge mode (control bit 4 = 0) the count steps from the start value up to the modulus and then returns to the start value, so a period is modulus-start+1 steps. The flag is set on that wrap.
- R4: In up-down mode (control bit 4 = 1) the count rises to the modulus and then falls back to the start value, so a period is 2*(modulus-start) steps. The flag is set on the turn from falling to rising.
- R5: Outside combined mode, a channel is active while count < compare. A compare of 0 is never active, and a compare above the modulus is always active.
- R6: When pair p's combine bit (address 7 bit p) is set, both pins of the pair are active while even compare <= count < odd compare.
- R7: Writes to the modulus (address 1), start (address 2) and compare buffers (address 16+ch) leave the active values unchanged until a reload. A pair's compares load only when its sync enable (address 7 bit NUM_CH/2+p) is set.
- R8: A reload happens at the count top when control bit 5 is set, at the up-down bottom turn when control bit 6 is set, and at a count equal to channel ch's active compare when address 8 bit ch is set.
- R9: Writing address 3 with bit 0 set commits all buffers at once. Bit 1 set restarts the count from the buffered start value, counting up, with the prescaler cleared.
- R10: Writing address 4 with bit 0 = 0 clears the flag when it is set. A set event in the same cycle wins. Writing 1, or writing while the flag is clear, changes nothing.
- R11: Polarity register (address 5) bit ch inverts output ch after the PWM logic.
- R12: With run (control bit 3) at 0, the count holds and each output shows initial-output register (address 6) bit ch. Buffer writes and sync strikes still take effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | 5 | Register address |
| wr_data | input | CNT_W | Write data |
| pwm_out | output | NUM_CH | PWM pin levels |
| count | output | CNT_W | Current counter value |
| ovf_flag | output | 1 | Sticky overflow flag |

## Verification
A wrong active compare or modulus shows on the pins within one period: the measured high time or period length differs from the programmed one. A premature commit shows as a pin that changes level at a count where the old compare would have held it, before the chosen reload point is reached. A wrong counter direction or prescaler phase appears on the count port at the next step. A flag that does not clear, or that sets spuriously, is visible one cycle after the write or the turn.

// File: rtl/pwmt_pkg.sv
package pwmt_pkg;
    localparam int ADDR_W = 5;

    localparam logic [ADDR_W-1:0] A_CTRL  = 5'd0;
    localparam logic [ADDR_W-1:0] A_MOD   = 5'd1;
    localparam logic [ADDR_W-1:0] A_START = 5'd2;
    localparam logic [ADDR_W-1:0] A_SYNC  = 5'd3;
    localparam logic [ADDR_W-1:0] A_FLAG  = 5'd4;
    localparam logic [ADDR_W-1:0] A_POL   = 5'd5;
    localparam logic [ADDR_W-1:0] A_INIT  = 5'd6;
    localparam logic [ADDR_W-1:0] A_PAIR  = 5'd7;
    localparam logic [ADDR_W-1:0] A_MATCH = 5'd8;
    localparam logic [ADDR_W-1:0] A_CMP0  = 5'd16;

    // control word; first field is the most significant bit
    typedef struct packed {
        logic       min_rl;   // bit 6: reload at up-down bottom
        logic       max_rl;   // bit 5: reload at count top
        logic       center;   // bit 4: up-down counting
        logic       run;      // bit 3: counter clock enable
        logic [2:0] ps;       // bits 2:0: prescale exponent
    } ctrl_t;

    localparam int CTRL_W = $bits(ctrl_t);
    localparam int DIV_W  = 7;

    function automatic logic [DIV_W-1:0] ps_mask(input logic [2:0] ps);
        return DIV_W'((1 << ps) - 1);
    endfunction
endpackage

// File: rtl/pwmt_regs.sv
module pwmt_regs
    import pwmt_pkg::*;
#(
    parameter int CW  = 16,
    parameter int NCH = 4
) (
    input  logic                     clk,
    input  logic                     rst,
    input  logic                     wr_en,
    input  logic [ADDR_W-1:0]        wr_addr,
    input  logic [CW-1:0]            wr_data,
    input  logic                     reload,
    input  logic                     ovf_evt,
    output ctrl_t                    ctrl,
    output logic [CW-1:0]            mod_act,
    output logic [CW-1:0]            start_act,
    output logic [CW-1:0]            start_buf,
    output logic [NCH-1:0][CW-1:0]   cmp_act,
    output logic [NCH-1:0]           pol,
    output logic [NCH-1:0]           init,
    output logic [NCH-1:0]           match_en,
    output logic [NCH/2-1:0]         combine,
    output logic                     sync_commit,
    output logic                     sync_restart,
    output logic                     ovf_flag
);
    localparam int NP = NCH / 2;

    logic [CW-1:0]          mod_buf;
    logic [NCH-1:0][CW-1:0] cmp_buf;
    logic [NP-1:0]          pair_sync;
    logic                   flag_clr;

    assign sync_commit  = wr_en && (wr_addr == A_SYNC) && wr_data[0];
    assign sync_restart = wr_en && (wr_addr == A_SYNC) && wr_data[1];
    assign flag_clr     = wr_en && (wr_addr == A_FLAG) && !wr_data[0];

    always_ff @(posedge clk) begin
        if (rst) begin
            ctrl      <= '0;
            mod_buf   <= '1;
            mod_act   <= '1;
            start_buf <= '0;
            start_act <= '0;
            cmp_buf   <= '0;
            cmp_act   <= '0;
            pol       <= '0;
            init      <= '0;
            match_en  <= '0;
            combine   <= '0;
            pair_sync <= '0;
            ovf_flag  <= 1'b0;
        end else begin
            if (wr_en) begin
                case (wr_addr)
                    A_CTRL:  ctrl      <= ctrl_t'(wr_data[CTRL_W-1:0]);
                    A_MOD:   mod_buf   <= wr_data;
                    A_START: start_buf <= wr_data;
                    A_POL:   pol       <= wr_data[NCH-1:0];
                    A_INIT:  init      <= wr_data[NCH-1:0];
                    A_MATCH: match_en  <= wr_data[NCH-1:0];
                    A_PAIR: begin
                        combine   <= wr_data[NP-1:0];
                        pair_sync <= wr_data[2*NP-1:NP];
                    end
                    default: ;
                endcase
                for (int ch = 0; ch < NCH; ch++) begin
                    if (wr_addr == A_CMP0 + ADDR_W'(ch))
                        cmp_buf[ch] <= wr_data;
                end
            end
            // commit uses the buffer contents held before this edge
            if (reload) begin
                mod_act   <= mod_buf;
                start_act <= start_buf;
                for (int ch = 0; ch < NCH; ch++) begin
                    if (pair_sync[ch/2])
                        cmp_act[ch] <= cmp_buf[ch];
                end
            end
            if (ovf_evt)
                ovf_flag <= 1'b1;
            else if (flag_clr && ovf_flag)
                ovf_flag <= 1'b0;
        end
    end
endmodule

// File: rtl/pwmt_counter.sv
module pwmt_counter
    import pwmt_pkg::*;
#(
    parameter int CW = 16
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          run,
    input  logic          center,
    input  logic [2:0]    ps,
    input  logic [CW-1:0] mod_val,
    input  logic [CW-1:0] start_val,
    input  logic          restart,
    input  logic [CW-1:0] restart_val,
    output logic [CW-1:0] count,
    output logic          tick,
    output logic          top_pt,
    output logic          bot_pt,
    output logic          wrap_evt
);
    logic [DIV_W-1:0] div;
    logic             up;
    logic             at_top;
    logic             at_bot;

    assign tick     = run && ((div & ps_mask(ps)) == ps_mask(ps));
    assign at_top   = count >= mod_val;
    assign at_bot   = count <= start_val;
    assign top_pt   = tick && at_top && (!center || up);
    assign bot_pt   = tick && center && !up && at_bot;
    assign wrap_evt = center ? bot_pt : (tick && at_top);

    always_ff @(posedge clk) begin
        if (rst) begin
            div   <= '0;
            count <= '0;
            up    <= 1'b1;
        end else if (restart) begin
            div   <= '0;
            count <= restart_val;
            up    <= 1'b1;
        end else begin
            if (run)
                div <= div + DIV_W'(1);
            if (tick) begin
                if (!center) begin
                    up    <= 1'b1;
                    count <= at_top ? start_val : count + CW'(1);
                end else if (up) begin
                    if (at_top) begin
                        up    <= 1'b0;
                        count <= count - CW'(1);
                    end else begin
                        count <= count + CW'(1);
                    end
                end else begin
                    if (at_bot) begin
                        up    <= 1'b1;
                        count <= count + CW'(1);
                    end else begin
                        count <= count - CW'(1);
                    end
                end
            end
        end
    end
endmodule

// File: rtl/pwmt_outputs.sv
module pwmt_outputs #(
    parameter int CW  = 16,
    parameter int NCH = 4
) (
    input  logic                   run,
    input  logic                   tick,
    input  logic [CW-1:0]          count,
    input  logic [NCH-1:0][CW-1:0] cmp,
    input  logic [NCH-1:0]         pol,
    input  logic [NCH-1:0]         init,
    input  logic [NCH-1:0]         match_en,
    input  logic [NCH/2-1:0]       combine,
    output logic [NCH-1:0]         pwm,
    output logic [NCH-1:0]         match_hit
);
    localparam int NP = NCH / 2;

    for (genvar p = 0; p < NP; p++) begin : g_pair
        logic win;
        logic raw_e;
        logic raw_o;
        assign win   = (count >= cmp[2*p]) && (count < cmp[2*p+1]);
        assign raw_e = combine[p] ? win : (count < cmp[2*p]);
        assign raw_o = combine[p] ? win : (count < cmp[2*p+1]);
        assign pwm[2*p]   = run ? (raw_e ^ pol[2*p])   : init[2*p];
        assign pwm[2*p+1] = run ? (raw_o ^ pol[2*p+1]) : init[2*p+1];
    end

    for (genvar ch = 0; ch < NCH; ch++) begin : g_match
        assign match_hit[ch] = tick && match_en[ch] && (count == cmp[ch]);
    end
endmodule

// File: rtl/pwm_timer.sv
module pwm_timer
    import pwmt_pkg::*;
#(
    parameter int CNT_W  = 16,
    parameter int NUM_CH = 4
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              wr_en,
    input  logic [ADDR_W-1:0] wr_addr,
    input  logic [CNT_W-1:0]  wr_data,
    output logic [NUM_CH-1:0] pwm_out,
    output logic [CNT_W-1:0]  count,
    output logic              ovf_flag
);
    ctrl_t                        ctrl;
    logic [CNT_W-1:0]             mod_act;
    logic [CNT_W-1:0]             start_act;
    logic [CNT_W-1:0]             start_buf;
    logic [NUM_CH-1:0][CNT_W-1:0] cmp_act;
    logic [NUM_CH-1:0]            pol;
    logic [NUM_CH-1:0]            init;
    logic [NUM_CH-1:0]            match_en;
    logic [NUM_CH-1:0]            match_hit;
    logic [NUM_CH/2-1:0]          combine;
    logic                         sync_commit;
    logic                         sync_restart;
    logic                         tick;
    logic                         top_pt;
    logic                         bot_pt;
    logic                         wrap_evt;
    logic                         reload;

    assign reload = sync_commit
                  | (top_pt & ctrl.max_rl)
                  | (bot_pt & ctrl.min_rl)
                  | (|match_hit);

    pwmt_regs #(.CW(CNT_W), .NCH(NUM_CH)) u_regs (
        .clk          (clk),
        .rst          (rst),
        .wr_en        (wr_en),
        .wr_addr      (wr_addr),
        .wr_data      (wr_data),
        .reload       (reload),
        .ovf_evt      (wrap_evt),
        .ctrl         (ctrl),
        .mod_act      (mod_act),
        .start_act    (start_act),
        .start_buf    (start_buf),
        .cmp_act      (cmp_act),
        .pol          (pol),
        .init         (init),
        .match_en     (match_en),
        .combine      (combine),
        .sync_commit  (sync_commit),
        .sync_restart (sync_restart),
        .ovf_flag     (ovf_flag)
    );

    pwmt_counter #(.CW(CNT_W)) u_counter (
        .clk         (clk),
        .rst         (rst),
        .run         (ctrl.run),
        .center      (ctrl.center),
        .ps          (ctrl.ps),
        .mod_val     (mod_act),
        .start_val   (start_act),
        .restart     (sync_restart),
        .restart_val (start_buf),
        .count       (count),
        .tick        (tick),
        .top_pt      (top_pt),
        .bot_pt      (bot_pt),
        .wrap_evt    (wrap_evt)
    );

    pwmt_outputs #(.CW(CNT_W), .NCH(NUM_CH)) u_outputs (
        .run       (ctrl.run),
        .tick      (tick),
        .count     (count),
        .cmp       (cmp_act),
        .pol       (pol),
        .init      (init),
        .match_en  (match_en),
        .combine   (combine),
        .pwm       (pwm_out),
        .match_hit (match_hit)
    );
endmodule

// File: rtl/pwmt_checker.sv
module pwmt_checker
    import pwmt_pkg::*;
#(
    parameter int CW  = 16,
    parameter int NCH = 4
) (
    input logic                   clk,
    input logic                   rst,
    input logic                   wr_en,
    input logic [ADDR_W-1:0]      wr_addr,
    input logic [CW-1:0]          wr_data,
    input logic                   ovf_flag,
    input logic                   ovf_evt,
    input logic [CW-1:0]          count,
    input logic                   tick,
    input logic                   run,
    input logic                   center,
    input logic                   restart,
    input logic                   reload,
    input logic [NCH-1:0][CW-1:0] cmp_act,
    input logic [CW-1:0]          start_act
);
    // R12: a stopped counter keeps its value
    assert_hold_stopped_R12: assert property (@(posedge clk) disable iff (rst)
        (!run && !restart) |=> $stable(count));

    // R10: write of 0 to a set flag clears it unless a new event arrives
    assert_flag_clear_R10: assert property (@(posedge clk) disable iff (rst)
        (ovf_flag && wr_en && wr_addr == A_FLAG && !wr_data[0] && !ovf_evt) |=> !ovf_flag);

    // R10: a clear flag stays clear without an overflow event
    assert_flag_quiet_R10: assert property (@(posedge clk) disable iff (rst)
        (!ovf_flag && !ovf_evt) |=> !ovf_flag);

    // R7: active compares move only on a reload
    assert_shadow_hold_R7: assert property (@(posedge clk) disable iff (rst)
        !reload |=> $stable(cmp_act));

    // R3: an edge-mode step is +1 or a return to the start value
    assert_edge_step_R3: assert property (@(posedge clk) disable iff (rst)
        (tick && !center && !restart) |=>
            ((count == $past(count) + CW'(1)) || (count == $past(start_act))));
endmodule

bind pwm_timer pwmt_checker #(.CW(CNT_W), .NCH(NUM_CH)) i_pwmt_checker (
    .clk       (clk),
    .rst       (rst),
    .wr_en     (wr_en),
    .wr_addr   (wr_addr),
    .wr_data   (wr_data),
    .ovf_flag  (ovf_flag),
    .ovf_evt   (wrap_evt),
    .count     (count),
    .tick      (tick),
    .run       (ctrl.run),
    .center    (ctrl.center),
    .restart   (sync_restart),
    .reload    (reload),
    .cmp_act   (cmp_act),
    .start_act (start_act)
);

// File: tb/test_pwm_timer.sv
module test_pwm_timer;
    import pwmt_pkg::*;

    localparam int CW  = 16;
    localparam int NCH = 4;

    logic              clk = 1'b0;
    logic              rst;
    logic              wr_en;
    logic [ADDR_W-1:0] wr_addr;
    logic [CW-1:0]     wr_data;
    logic [NCH-1:0]    pwm_out;
    logic [CW-1:0]     count;
    logic              ovf_flag;

    int checks = 0;
    int errors = 0;
    int hi [NCH];
    bit done = 0;

    always #5 clk = ~clk;

    pwm_timer #(.CNT_W(CW), .NUM_CH(NCH)) i_pwm_timer (
        .clk      (clk),
        .rst      (rst),
        .wr_en    (wr_en),
        .wr_addr  (wr_addr),
        .wr_data  (wr_data),
        .pwm_out  (pwm_out),
        .count    (count),
        .ovf_flag (ovf_flag)
    );

    task automatic chk(input string req, input int act, input int exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: got %0d expected %0d", req, act, exp);
        end
    endtask

    task automatic wr(input logic [ADDR_W-1:0] a, input int d);
        @(negedge clk);
        wr_en   = 1'b1;
        wr_addr = a;
        wr_data = CW'(d);
        @(negedge clk);
        wr_en   = 1'b0;
    endtask

    task automatic wait_cnt(input int v);
        for (int i = 0; i < 2000; i++) begin
            @(negedge clk);
            if (count == CW'(v)) return;
        end
        chk("wait for count", int'(count), v);
    endtask

    task automatic measure(input int n);
        for (int c = 0; c < NCH; c++) hi[c] = 0;
        for (int i = 0; i < n; i++) begin
            @(negedge clk);
            for (int c = 0; c < NCH; c++) hi[c] += int'(pwm_out[c]);
        end
    endtask

    task automatic t_reset;
        chk("R1 count", int'(count), 0);
        chk("R1 outputs", int'(pwm_out), 0);
        chk("R1 flag", int'(ovf_flag), 0);
    endtask

    task automatic t_stopped_setup;
        wr(A_INIT, 5);
        chk("R12 init level", int'(pwm_out), 5);
        wr(A_MOD, 99);
        wr(A_CMP0 + 5'd0, 0);
        wr(A_CMP0 + 5'd1, 50);
        wr(A_CMP0 + 5'd2, 100);
        wr(A_CMP0 + 5'd3, 25);
        wr(A_PAIR, 'hC);
        wr(A_SYNC, 1);
        repeat (5) @(negedge clk);
        chk("R12 count held", int'(count), 0);
        chk("R12 init kept", int'(pwm_out), 5);
        wr(A_CTRL, 'h28);
    endtask

    task automatic t_edge;
        wait_cnt(99);
        measure(100);
        chk("R5 duty 0%", hi[0], 0);
        chk("R5 duty 50%", hi[1], 50);
        chk("R5 duty 100%", hi[2], 100);
        chk("R5 duty 25%", hi[3], 25);
        chk("R3 top value", int'(count), 99);
        @(negedge clk);
        chk("R3 wrap to start", int'(count), 0);
        chk("R3 flag set", int'(ovf_flag), 1);
    endtask

    task automatic t_flag;
        wait_cnt(5);
        wr(A_FLAG, 0);
        chk("R10 clear", int'(ovf_flag), 0);
        wr(A_FLAG, 0);
        chk("R10 clear while clear", int'(ovf_flag), 0);
        wait_cnt(99);
        @(negedge clk);
        chk("R3 flag on wrap", int'(ovf_flag), 1);
        wr(A_FLAG, 1);
        chk("R10 write 1 keeps", int'(ovf_flag), 1);
    endtask

    task automatic t_pol;
        wr(A_POL, 1);
        wait_cnt(99);
        measure(100);
        chk("R11 inverted 0%", hi[0], 100);
        chk("R11 other channel", hi[1], 50);
        wr(A_POL, 0);
    endtask

    task automatic t_buffer;
        wait_cnt(10);
        wr(A_CMP0 + 5'd1, 80);
        wait_cnt(60);
        chk("R7 no early update", int'(pwm_out[1]), 0);
        wait_cnt(99);
        measure(100);
        chk("R8 top reload", hi[1], 80);
        wr(A_PAIR, 'h4);
        wr(A_CMP0 + 5'd3, 75);
        wait_cnt(99);
        measure(100);
        chk("R7 pair sync off", hi[3], 25);
        wr(A_PAIR, 'hC);
        wait_cnt(99);
        @(negedge clk);
    endtask

    task automatic t_match;
        wr(A_CTRL, 'h08);
        wr(A_MATCH, 'h8);
        wait_cnt(0);
        wr(A_CMP0 + 5'd1, 20);
        wait_cnt(70);
        chk("R8 before match", int'(pwm_out[1]), 1);
        wait_cnt(78);
        chk("R8 after match", int'(pwm_out[1]), 0);
        wr(A_MATCH, 0);
    endtask

    task automatic t_combined;
        wr(A_CTRL, 'h28);
        wr(A_CMP0 + 5'd0, 30);
        wr(A_CMP0 + 5'd1, 70);
        wr(A_PAIR, 'hD);
        wait_cnt(99);
        measure(100);
        chk("R6 even width", hi[0], 40);
        chk("R6 odd width", hi[1], 40);
        wait_cnt(29);
        chk("R6 before lead", int'(pwm_out[0]), 0);
        @(negedge clk);
        chk("R6 lead edge", int'(pwm_out[0]), 1);
        wait_cnt(69);
        chk("R6 before trail", int'(pwm_out[1]), 1);
        @(negedge clk);
        chk("R6 trail edge", int'(pwm_out[1]), 0);
    endtask

    task automatic t_center;
        wr(A_PAIR, 'hC);
        wr(A_MOD, 8);
        wr(A_CMP0 + 5'd0, 0);
        wr(A_CMP0 + 5'd1, 4);
        wr(A_CMP0 + 5'd2, 9);
        wr(A_CMP0 + 5'd3, 8);
        wr(A_CTRL, 'h58);
        wr(A_SYNC, 3);
        wr(A_FLAG, 0);
        wait_cnt(0);
        chk("R4 no flag before turn", int'(ovf_flag), 0);
        measure(16);
        chk("R4 period", int'(count), 0);
        chk("R4 flag at bottom", int'(ovf_flag), 1);
        chk("R5 center 0%", hi[0], 0);
        chk("R5 center width", hi[1], 7);
        chk("R5 center 100%", hi[2], 16);
        chk("R5 center near top", hi[3], 15);
        wait_cnt(8);
        @(negedge clk);
        chk("R4 turn down", int'(count), 7);
        wait_cnt(0);
        wr(A_CMP0 + 5'd1, 2);
        wait_cnt(8);
        wait_cnt(3);
        chk("R8 no top reload", int'(pwm_out[1]), 1);
        wait_cnt(0);
        wait_cnt(3);
        chk("R8 bottom reload", int'(pwm_out[1]), 0);
    endtask

    task automatic t_restart;
        wr(A_CTRL, 'h28);
        wr(A_START, 3);
        wait_cnt(6);
        wr(A_SYNC, 3);
        chk("R9 restart value", int'(count), 3);
        wait_cnt(8);
        @(negedge clk);
        chk("R9 new start on wrap", int'(count), 3);
    endtask

    task automatic t_prescale;
        int prev;
        int chg;
        wr(A_CTRL, 'h2A);
        prev = int'(count);
        chg  = 0;
        for (int i = 0; i < 16; i++) begin
            @(negedge clk);
            if (int'(count) != prev) chg++;
            prev = int'(count);
        end
        chk("R2 steps per 16 clocks", chg, 4);
    endtask

    task automatic t_stop;
        int held;
        wr(A_CTRL, 'h22);
        held = int'(count);
        repeat (10) @(negedge clk);
        chk("R12 stop holds", int'(count), held);
        chk("R12 stop init", int'(pwm_out), 5);
        wr(A_MOD, 5);
        wr(A_SYNC, 1);
        wr(A_CTRL, 'h28);
        wait_cnt(5);
        @(negedge clk);
        chk("R12 buffered while stopped", int'(count), 3);
    endtask

    initial begin
        rst     = 1'b1;
        wr_en   = 1'b0;
        wr_addr = '0;
        wr_data = '0;
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        t_reset();
        t_stopped_setup();
        t_edge();
        t_flag();
        t_pol();
        t_buffer();
        t_match();
        t_combined();
        t_center();
        t_restart();
        t_prescale();
        t_stop();
        done = 1;
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        #1_000_000;
        if (!done) begin
            checks++;
            errors++;
            $display("FAIL watchdog: got 0 expected 1 (run completed)");
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end
endmodule